// File: doc/BRIEF.md
# Doorbell-and-Payload Gated Acknowledger

This block is the receiving-side agent of an inter-processor mailbox. After reset it polls the sender's flag register over a shared mailbox port. It waits for two things that arrive independently: the sender's doorbell bit in that flag, and a separate payload-complete level from the data path. The doorbell on its own never produces a reply.

Once both hold, the agent fetches the sender's command word. It copies that word into the reply-command register and then writes the acknowledge code into the reply-flag register. It then parks in a terminal done state. A sender that sees the acknowledge can therefore trust two things: the payload has landed, and the echoed command is already in place. The agent is strictly one-shot, and only reset arms it for another exchange.

The mailbox port carries a single-cycle read request, answered later by a read-valid strobe with data, and a single-cycle write request. Both share one address bus.

Top module: `mbx_ack_agent`

## Requirements
- R1: During reset and in the first cycle after it, `done` is 0 and `ack_count` is 0. The first mailbox access after reset is a read of the sender flag at offset 0x30.
- R2: Each poll is a read request of exactly one cycle at offset 0x30. No further read is issued until `mb_rd_valid` has returned the data of the previous read.
- R3: While `payload_done` is low, the agent issues no write and `done` stays 0, whatever value the sender flag holds, including when bit 0 (the doorbell, value 0x1) is set.
- R4: While bit 0 of the sender flag is clear, the agent issues no write and `done` stays 0, even with `payload_done` high and other flag bits set.
- R5: `payload_done` is taken as a level. A completion that is already high before the doorbell appears leads to an acknowledge once the doorbell is seen.
- R6: Once the doorbell and `payload_done` are both seen, the agent reads the sender command at offset 0x10 exactly once. It writes that same value to the reply-command register at offset 0x00.
- R7: The reply flag at offset 0x20 is written with the value 0x2 in the cycle directly after the reply-command write. Exactly two writes occur in an exchange.
- R8: A read request and a write request are never asserted in the same cycle.
- R9: After the reply-flag write, `done` is 1 and stays 1. `ack_count` reads exactly 1, and no further mailbox access is issued until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| payload_done | input | 1 | Level: the payload transfer has completed |
| mb_rd_req | output | 1 | One-cycle mailbox read request |
| mb_wr_req | output | 1 | One-cycle mailbox write request |
| mb_addr | output | ADDR_W (8) | Mailbox register offset for the read or write |
| mb_wr_data | output | DATA_W (32) | Write data |
| mb_rd_data | input | DATA_W (32) | Read data, valid with `mb_rd_valid` |
| mb_rd_valid | input | 1 | Read response strobe |
| done | output | 1 | Exchange acknowledged; terminal |
| ack_count | output | CNT_W (8) | Number of acknowledges issued since reset |

## Verification
The assertions take for granted that the mailbox answers each read with exactly one `mb_rd_valid` pulse. They also take for granted that no valid pulse arrives without an outstanding read, and that `payload_done`, once high, stays high until reset. The bench's mailbox model therefore returns one response per request, after a latency of one to three cycles. The stimulus only ever raises `payload_done` and the doorbell, and lowers them only while reset is held. Each trial begins with a fresh reset, because the agent is one-shot.

// File: rtl/mbx_ack_pkg.sv
package mbx_ack_pkg;

   typedef enum logic [2:0] {
      ST_POLL_ISSUE = 3'd0,
      ST_POLL_WAIT  = 3'd1,
      ST_CMD_ISSUE  = 3'd2,
      ST_CMD_WAIT   = 3'd3,
      ST_WR_CMD     = 3'd4,
      ST_WR_FLAG    = 3'd5,
      ST_DONE       = 3'd6
   } agent_state_e;

   typedef enum logic [1:0] {
      SEL_SND_FLAG = 2'd0,
      SEL_SND_CMD  = 2'd1,
      SEL_RPL_CMD  = 2'd2,
      SEL_RPL_FLAG = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/mbx_ack_seq.sv
module mbx_ack_seq
   import mbx_ack_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int DOORBELL_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              payload_done,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              want_rd,
   output logic              want_wr,
   output reg_sel_e          sel,
   output logic [DATA_W-1:0] cmd_q,
   output logic              done,
   output logic              ack_pulse
);

   agent_state_e state_q, state_d;
   logic [DATA_W-1:0] cmd_d;

   always_comb begin
      state_d = state_q;
      cmd_d   = cmd_q;
      unique case (state_q)
         ST_POLL_ISSUE: state_d = ST_POLL_WAIT;
         ST_POLL_WAIT: begin
            if (rd_valid) begin
               if (rd_data[DOORBELL_BIT] && payload_done)
                  state_d = ST_CMD_ISSUE;
               else
                  state_d = ST_POLL_ISSUE;
            end
         end
         ST_CMD_ISSUE: state_d = ST_CMD_WAIT;
         ST_CMD_WAIT: begin
            if (rd_valid) begin
               cmd_d   = rd_data;
               state_d = ST_WR_CMD;
            end
         end
         ST_WR_CMD:  state_d = ST_WR_FLAG;
         ST_WR_FLAG: state_d = ST_DONE;
         ST_DONE:    state_d = ST_DONE;
         default:    state_d = ST_POLL_ISSUE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_POLL_ISSUE;
         cmd_q   <= '0;
      end else begin
         state_q <= state_d;
         cmd_q   <= cmd_d;
      end
   end

   always_comb begin
      want_rd   = (state_q == ST_POLL_ISSUE) || (state_q == ST_CMD_ISSUE);
      want_wr   = (state_q == ST_WR_CMD) || (state_q == ST_WR_FLAG);
      done      = (state_q == ST_DONE);
      ack_pulse = (state_q == ST_WR_FLAG);
      unique case (state_q)
         ST_CMD_ISSUE: sel = SEL_SND_CMD;
         ST_WR_CMD:    sel = SEL_RPL_CMD;
         ST_WR_FLAG:   sel = SEL_RPL_FLAG;
         default:      sel = SEL_SND_FLAG;
      endcase
   end

   // R3: the command fetch only starts after payload-complete was seen
   assert_gate_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CMD_ISSUE) |-> $past(payload_done));

   // R4: the command fetch only starts after a poll returned the doorbell
   assert_gate_doorbell_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CMD_ISSUE) |-> ($past(rd_valid) && $past(rd_data[DOORBELL_BIT])));

   // R9: terminal state is sticky
   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

endmodule

// File: rtl/mbx_port_drive.sv
module mbx_port_drive
   import mbx_ack_pkg::*;
#(
   parameter int              ADDR_W    = 8,
   parameter int              DATA_W    = 32,
   parameter logic [ADDR_W-1:0] OFS_RPL_CMD  = 8'h00,
   parameter logic [ADDR_W-1:0] OFS_SND_CMD  = 8'h10,
   parameter logic [ADDR_W-1:0] OFS_RPL_FLAG = 8'h20,
   parameter logic [ADDR_W-1:0] OFS_SND_FLAG = 8'h30,
   parameter logic [DATA_W-1:0] ACK_VALUE    = 32'h2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              want_rd,
   input  logic              want_wr,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] cmd_q,
   output logic              mb_rd_req,
   output logic              mb_wr_req,
   output logic [ADDR_W-1:0] mb_addr,
   output logic [DATA_W-1:0] mb_wr_data
);

   always_comb begin
      mb_rd_req  = want_rd && !want_wr;
      mb_wr_req  = want_wr;
      mb_wr_data = '0;
      unique case (sel)
         SEL_SND_FLAG: mb_addr = OFS_SND_FLAG;
         SEL_SND_CMD:  mb_addr = OFS_SND_CMD;
         SEL_RPL_CMD: begin
            mb_addr    = OFS_RPL_CMD;
            mb_wr_data = cmd_q;
         end
         default: begin
            mb_addr    = OFS_RPL_FLAG;
            mb_wr_data = ACK_VALUE;
         end
      endcase
   end

   // R8: read and write never share a cycle
   assert_rdwr_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mb_rd_req && mb_wr_req));

   // R2: every read request lasts a single cycle
   assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mb_rd_req |=> !mb_rd_req);

   // R7: flag write carries the ack code and directly follows the command write
   assert_ack_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_wr_req && mb_addr == OFS_RPL_FLAG) |-> (mb_wr_data == ACK_VALUE));

   assert_ack_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_wr_req && mb_addr == OFS_RPL_FLAG) |-> ($past(mb_wr_req) && $past(mb_addr) == OFS_RPL_CMD));

endmodule

// File: rtl/mbx_ack_tally.sv
module mbx_ack_tally #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (inc && count != CNT_MAX)
         count <= count + 1'b1;
   end

endmodule

// File: rtl/mbx_ack_agent.sv
module mbx_ack_agent
   import mbx_ack_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int CNT_W        = 8,
   parameter int DOORBELL_BIT = 0,
   parameter logic [ADDR_W-1:0] OFS_RPL_CMD  = 8'h00,
   parameter logic [ADDR_W-1:0] OFS_SND_CMD  = 8'h10,
   parameter logic [ADDR_W-1:0] OFS_RPL_FLAG = 8'h20,
   parameter logic [ADDR_W-1:0] OFS_SND_FLAG = 8'h30,
   parameter logic [DATA_W-1:0] ACK_VALUE    = 32'h2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              payload_done,
   output logic              mb_rd_req,
   output logic              mb_wr_req,
   output logic [ADDR_W-1:0] mb_addr,
   output logic [DATA_W-1:0] mb_wr_data,
   input  logic [DATA_W-1:0] mb_rd_data,
   input  logic              mb_rd_valid,
   output logic              done,
   output logic [CNT_W-1:0]  ack_count
);

   if (DOORBELL_BIT < 0 || DOORBELL_BIT >= DATA_W) begin : g_bad_doorbell
      $error("DOORBELL_BIT outside the data word");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (OFS_RPL_CMD == OFS_SND_CMD || OFS_RPL_CMD == OFS_RPL_FLAG ||
       OFS_RPL_CMD == OFS_SND_FLAG || OFS_SND_CMD == OFS_RPL_FLAG ||
       OFS_SND_CMD == OFS_SND_FLAG || OFS_RPL_FLAG == OFS_SND_FLAG) begin : g_bad_map
      $error("mailbox offsets must be distinct");
   end

   logic              want_rd, want_wr, ack_pulse;
   reg_sel_e          sel;
   logic [DATA_W-1:0] cmd_q;

   mbx_ack_seq #(
      .DATA_W       (DATA_W),
      .DOORBELL_BIT (DOORBELL_BIT)
   ) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .payload_done (payload_done),
      .rd_valid     (mb_rd_valid),
      .rd_data      (mb_rd_data),
      .want_rd      (want_rd),
      .want_wr      (want_wr),
      .sel          (sel),
      .cmd_q        (cmd_q),
      .done         (done),
      .ack_pulse    (ack_pulse)
   );

   mbx_port_drive #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .OFS_RPL_CMD  (OFS_RPL_CMD),
      .OFS_SND_CMD  (OFS_SND_CMD),
      .OFS_RPL_FLAG (OFS_RPL_FLAG),
      .OFS_SND_FLAG (OFS_SND_FLAG),
      .ACK_VALUE    (ACK_VALUE)
   ) drive_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .want_rd    (want_rd),
      .want_wr    (want_wr),
      .sel        (sel),
      .cmd_q      (cmd_q),
      .mb_rd_req  (mb_rd_req),
      .mb_wr_req  (mb_wr_req),
      .mb_addr    (mb_addr),
      .mb_wr_data (mb_wr_data)
   );

   mbx_ack_tally #(.CNT_W(CNT_W)) tally_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ack_pulse),
      .count (ack_count)
   );

   // R9: the counter and the done flag agree; one-shot means exactly one
   assert_one_shot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ack_count == CNT_W'(1)));

   assert_no_early_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (ack_count == '0));

   // R9: no mailbox traffic after done
   assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(mb_rd_req || mb_wr_req));

endmodule

// File: tb/mbx_ack_agent_tb_top.sv
`timescale 1ns/1ps
module mbx_ack_agent_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_RPL_CMD  = 8'h00;
   localparam logic [7:0] A_SND_CMD  = 8'h10;
   localparam logic [7:0] A_RPL_FLAG = 8'h20;
   localparam logic [7:0] A_SND_FLAG = 8'h30;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        payload_done;
   logic        mb_rd_req, mb_wr_req;
   logic [7:0]  mb_addr;
   logic [31:0] mb_wr_data;
   logic [31:0] mb_rd_data;
   logic        mb_rd_valid;
   logic        done;
   logic [7:0]  ack_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_ack_agent dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .payload_done (payload_done),
      .mb_rd_req    (mb_rd_req),
      .mb_wr_req    (mb_wr_req),
      .mb_addr      (mb_addr),
      .mb_wr_data   (mb_wr_data),
      .mb_rd_data   (mb_rd_data),
      .mb_rd_valid  (mb_rd_valid),
      .done         (done),
      .ack_count    (ack_count)
   );

   // mailbox model and monitors
   logic [31:0] snd_flag, snd_cmd, rpl_cmd, rpl_flag;
   int lat;
   logic pend, prev_rd;
   int   cnt;
   logic [7:0] paddr;
   int cyc, wr_cnt, cmd_wr_cyc, flag_wr_cyc, cmd_rd_cnt, poll_cnt;
   int bad_rd, bad_rw, late_acc, bad_addr;
   logic first_seen;
   logic [7:0] first_addr;
   logic first_is_rd;

   int checks = 0;
   int errors = 0;

   function automatic logic [31:0] lookup(input logic [7:0] a);
      case (a)
         A_SND_FLAG: return snd_flag;
         A_SND_CMD:  return snd_cmd;
         A_RPL_CMD:  return rpl_cmd;
         A_RPL_FLAG: return rpl_flag;
         default:    return 32'hBAD0_BAD0;
      endcase
   endfunction

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         pend <= 1'b0;
         mb_rd_valid <= 1'b0;
         prev_rd = 1'b0;
      end else begin
         mb_rd_valid <= 1'b0;
         if (pend) begin
            if (cnt <= 1) begin
               mb_rd_valid <= 1'b1;
               mb_rd_data  <= lookup(paddr);
               pend <= 1'b0;
            end else cnt <= cnt - 1;
         end
         if (mb_rd_req || mb_wr_req) begin
            if (!first_seen) begin
               first_seen  = 1'b1;
               first_addr  = mb_addr;
               first_is_rd = mb_rd_req;
            end
            if (done) late_acc = late_acc + 1;
         end
         if (mb_rd_req && mb_wr_req) bad_rw = bad_rw + 1;
         if (mb_rd_req) begin
            if (pend || prev_rd) bad_rd = bad_rd + 1;
            pend  <= 1'b1;
            paddr <= mb_addr;
            cnt   <= lat;
            if (mb_addr == A_SND_CMD) cmd_rd_cnt = cmd_rd_cnt + 1;
            else if (mb_addr == A_SND_FLAG) poll_cnt = poll_cnt + 1;
            else bad_addr = bad_addr + 1;
         end
         if (mb_wr_req) begin
            wr_cnt = wr_cnt + 1;
            if (mb_addr == A_RPL_CMD) begin rpl_cmd = mb_wr_data; cmd_wr_cyc = cyc; end
            else if (mb_addr == A_RPL_FLAG) begin rpl_flag = mb_wr_data; flag_wr_cyc = cyc; end
            else bad_addr = bad_addr + 1;
         end
         prev_rd = mb_rd_req;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic [31:0] flag, input logic pd, input logic [31:0] cmd);
      @(negedge clk);
      rst_n = 1'b0;
      snd_flag = flag; snd_cmd = cmd; payload_done = pd;
      rpl_cmd = 32'h0; rpl_flag = 32'h0;
      wr_cnt = 0; cmd_wr_cyc = -10; flag_wr_cyc = -20; cmd_rd_cnt = 0; poll_cnt = 0;
      bad_rd = 0; bad_rw = 0; late_acc = 0; bad_addr = 0;
      first_seen = 1'b0; first_addr = 8'hFF; first_is_rd = 1'b0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1", "done in reset", done, 0);
      chk(ack_count == 8'd0, "R1", "count in reset", ack_count, 0);
      rst_n = 1'b1;
   endtask

   task automatic check_acked(input logic [31:0] cmd);
      chk(done == 1'b1, "R9", "done after ack", done, 1);
      chk(ack_count == 8'd1, "R9", "ack_count", ack_count, 1);
      chk(cmd_rd_cnt == 1, "R6", "command reads", cmd_rd_cnt, 1);
      chk(rpl_cmd == cmd, "R6", "echoed command", rpl_cmd, cmd);
      chk(rpl_flag == 32'h2, "R7", "reply flag value", rpl_flag, 2);
      chk(flag_wr_cyc == cmd_wr_cyc + 1, "R7", "flag write cycle", flag_wr_cyc, cmd_wr_cyc + 1);
      chk(wr_cnt == 2, "R7", "write count", wr_cnt, 2);
   endtask

   task automatic run_trial(input logic [2:0] flag, input logic pd, input int l);
      logic [31:0] cmd;
      logic        exp_ack;
      cmd = 32'hC0DE_0000 | (32'(flag) << 8) | (32'(pd) << 4) | 32'(l);
      lat = l;
      do_reset({29'h0, flag}, pd, cmd);
      @(negedge clk);
      chk(done == 1'b0 && ack_count == 8'd0, "R1", "state after reset", {done, ack_count}, 0);
      repeat (40) @(negedge clk);
      chk(first_seen && first_is_rd && first_addr == A_SND_FLAG, "R1", "first access",
          first_addr, A_SND_FLAG);
      exp_ack = flag[0] & pd;
      if (exp_ack) begin
         check_acked(cmd);
      end else begin
         chk(wr_cnt == 0 && done == 1'b0,
             pd ? "R4" : "R3", "held without both conditions", wr_cnt, 0);
         chk(ack_count == 8'd0, pd ? "R4" : "R3", "count while held", ack_count, 0);
         chk(poll_cnt >= 3, "R2", "polls repeat", poll_cnt, 3);
         // supply the missing condition(s)
         snd_flag = snd_flag | 32'h1;
         payload_done = 1'b1;
         repeat (40) @(negedge clk);
         if (pd) chk(done == 1'b1, "R5", "early completion honoured", done, 1);
         check_acked(cmd);
      end
      // change the sender side and wait: nothing further may happen
      snd_cmd = ~cmd;
      snd_flag = 32'h0;
      repeat (50) @(negedge clk);
      chk(done == 1'b1 && ack_count == 8'd1, "R9", "stays done", ack_count, 1);
      chk(late_acc == 0 && rpl_cmd == cmd, "R9", "no access after done", late_acc, 0);
      chk(bad_rd == 0, "R2", "read overlap or long pulse", bad_rd, 0);
      chk(bad_rw == 0, "R8", "read and write together", bad_rw, 0);
      chk(bad_addr == 0, "R6", "unexpected address", bad_addr, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      payload_done = 1'b0;
      snd_flag = 0; snd_cmd = 0; rpl_cmd = 0; rpl_flag = 0;
      lat = 1; cyc = 0; cnt = 0; paddr = 0; mb_rd_data = 0;
      for (int l = 1; l <= 3; l++)
         for (int pd = 0; pd < 2; pd++)
            for (int f = 0; f < 8; f++)
               run_trial(f[2:0], pd[0], l);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule